// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt control unit of a small 8-bit core. It collects maskable interrupt requests and one active-low non-maskable request into internal pending latches. At each instruction-boundary strobe it decides whether to take an interrupt. When it takes one, it saves the current program counter on a hardware return stack, switches the core's operating mode and hands a vector address to the fetch unit through a one-cycle load strobe.

The block owns three independent carry/zero flag pairs: one for normal execution, one for maskable-interrupt service and one for non-maskable service. The datapath always reads and writes the pair that belongs to the current mode, so flags are never saved in memory. A return-from-interrupt strobe pops the saved program counter and restores the previous mode together with its flag pair.

Decoding, the ALU and any software polling of interrupt sources lie outside this block. All pins are plain control and status signals. There is no data stream and no valid/ready handshake, because every exchange fits in a single strobe cycle.

Top module: `irq_seq`

## Requirements
- R1: After reset, `mode_o` is 0 (normal), `pc_load` is 0, `stk_ovf` is 0, no request is pending, and all three flag pairs read as C=0, Z=0.
- R2: A maskable request is taken at an `ins_end` cycle only when `gie` is 1, the mode is normal (0) and at least one maskable latch is pending. In the following cycle `pc_load` is 1, `pc_out` carries the vector and `mode_o` is 1.
- R3: Among pending maskable sources, the lowest index wins. Source i gets vector 0xFFC - 2*(i+1), so with a 12-bit PC source 0 gets 0xFFA and source 3 gets 0xFF4. A latch sets on a rising edge of its `irq_req` bit and is cleared when that source is taken.
- R4: A pending non-maskable request is taken at `ins_end` in normal or maskable-interrupt mode, whatever the value of `gie`. It beats any maskable request, loads vector 0xFFC and sets `mode_o` to 2.
- R5: The non-maskable latch sets only on a falling edge of `nmi_n`. Holding `nmi_n` low therefore causes exactly one entry.
- R6: On entry, `pc_in` is pushed on the return stack. A `reti` strobe outside normal mode pops that value into `pc_out` with `pc_load` high in the next cycle. The mode goes from 1 back to 0, and from 2 back to whichever mode was active before the non-maskable entry.
- R7: `c_o`/`z_o` show the flag pair of the current mode. A `flg_we` write changes only that pair.
- R8: Maskable requests are never taken in mode 1 or mode 2. They stay pending and are taken after the return to normal mode. A non-maskable request arriving while in mode 2 waits until that mode is left.
- R9: `stk_ovf` sets when a push happens with all levels full, and it stays set until reset.
- R10: A `reti` strobe in normal mode is ignored: no load strobe and no mode change. A `reti` strobe always takes precedence over a concurrent `ins_end`.
- R11: Requests are acted on only at `ins_end`. Without `ins_end` or `reti`, the mode does not change and `pc_load` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N_SRC | Maskable request lines, rising edge latched |
| nmi_n | input | 1 | Non-maskable request, falling edge latched |
| gie | input | 1 | Global maskable-interrupt enable |
| ins_end | input | 1 | Instruction-boundary strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| pc_in | input | PC_W | Current program counter |
| pc_load | output | 1 | One-cycle strobe: load `pc_out` into the PC |
| pc_out | output | PC_W | Vector or restored PC |
| mode_o | output | 2 | 0 normal, 1 maskable service, 2 non-maskable service |
| flg_we | input | 1 | Write strobe for the active flag pair |
| c_wr | input | 1 | Carry value to write |
| z_wr | input | 1 | Zero value to write |
| c_o | output | 1 | Active carry flag |
| z_o | output | 1 | Active zero flag |
| stk_ovf | output | 1 | Sticky return-stack overflow |

## Verification
The bench builds the main instance with the default values: four sources, a 12-bit PC and a six-level stack. This exposes the priority order across all four vectors, nested non-maskable entry from maskable service, and the three flag pairs. Because interrupt nesting never goes deeper than two levels, the default stack can never overflow. A second instance with a single-level stack shares the same inputs, so one nested entry is enough to set its overflow flag while the main instance's flag must stay clear.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_IRQ  = 2'd1,
    MODE_NMI  = 2'd2
  } mode_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int W       = 4,
  parameter bit ACT_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  logic [W-1:0] sig_q;
  logic [W-1:0] edge_hit;

  generate
    if (ACT_LOW) begin : g_fall
      assign edge_hit = ~sig & sig_q;
    end else begin : g_rise
      assign edge_hit = sig & ~sig_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= ACT_LOW ? '1 : '0;
      pend  <= '0;
    end else begin
      sig_q <= sig;
      // a new edge in the same cycle as a clear keeps the latch set
      pend  <= (pend & ~clr) | edge_hit;
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_seq_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int PC_W  = 12
) (
  input  logic [N_SRC-1:0] pend,
  input  logic             nmi_pend,
  input  logic             gie,
  input  mode_e            mode,
  output logic             take_nmi,
  output logic             take_irq,
  output logic [N_SRC-1:0] grant,
  output logic [PC_W-1:0]  vec
);
  localparam logic [PC_W-1:0] TOP_ADDR = '1;
  localparam logic [PC_W-1:0] NMI_VEC  = TOP_ADDR - PC_W'(3);

  logic [PC_W-1:0] irq_vec;
  logic [N_SRC-1:0] sel;

  always_comb begin
    sel     = '0;
    irq_vec = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        sel     = '0;
        sel[i]  = 1'b1;
        irq_vec = NMI_VEC - PC_W'(2 * (i + 1));
      end
    end
  end

  assign take_nmi = nmi_pend && (mode != MODE_NMI);
  assign take_irq = !take_nmi && gie && (mode == MODE_NORM) && (|pend);
  assign grant    = take_irq ? sel : '0;
  assign vec      = take_nmi ? NMI_VEC : irq_vec;
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
  parameter int DEPTH = 6,
  parameter int PC_W  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] din,
  output logic [PC_W-1:0] top,
  output logic            ovf
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [PC_W-1:0] lvl [DEPTH];
  logic [CW-1:0]   cnt;

  assign top = lvl[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) lvl[k] <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else if (push) begin
      lvl[0] <= din;
      for (int k = 1; k < DEPTH; k++) lvl[k] <= lvl[k-1];
      if (cnt == CW'(DEPTH)) ovf <= 1'b1;
      else                   cnt <= cnt + 1'b1;
    end else if (pop) begin
      for (int k = 0; k < DEPTH - 1; k++) lvl[k] <= lvl[k+1];
      lvl[DEPTH-1] <= '0;
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  logic  we,
  input  logic  c_wr,
  input  logic  z_wr,
  output logic  c_o,
  output logic  z_o
);
  logic [2:0] bank_c;
  logic [2:0] bank_z;

  always_comb begin
    case (mode)
      MODE_IRQ: begin c_o = bank_c[1]; z_o = bank_z[1]; end
      MODE_NMI: begin c_o = bank_c[2]; z_o = bank_z[2]; end
      default:  begin c_o = bank_c[0]; z_o = bank_z[0]; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_c <= '0;
      bank_z <= '0;
    end else if (we) begin
      case (mode)
        MODE_IRQ: begin bank_c[1] <= c_wr; bank_z[1] <= z_wr; end
        MODE_NMI: begin bank_c[2] <= c_wr; bank_z[2] <= z_wr; end
        default:  begin bank_c[0] <= c_wr; bank_z[0] <= z_wr; end
      endcase
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int N_SRC     = 4,
  parameter int PC_W      = 12,
  parameter int STK_DEPTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             nmi_n,
  input  logic             gie,
  input  logic             ins_end,
  input  logic             reti,
  input  logic [PC_W-1:0]  pc_in,
  output logic             pc_load,
  output logic [PC_W-1:0]  pc_out,
  output logic [1:0]       mode_o,
  input  logic             flg_we,
  input  logic             c_wr,
  input  logic             z_wr,
  output logic             c_o,
  output logic             z_o,
  output logic             stk_ovf
);
  mode_e            mode;
  logic             nest_from_irq;
  logic [N_SRC-1:0] irq_pend;
  logic             nmi_pend;
  logic             take_nmi;
  logic             take_irq;
  logic [N_SRC-1:0] grant;
  logic [PC_W-1:0]  vec;
  logic [PC_W-1:0]  stk_top;
  logic             do_push;
  logic             do_pop;

  assign do_pop  = reti && (mode != MODE_NORM);
  assign do_push = ins_end && !reti && (take_nmi || take_irq);

  irq_edge_latch #(.W(N_SRC), .ACT_LOW(1'b0)) u_irq_lat (
    .clk(clk), .rst_n(rst_n), .sig(irq_req),
    .clr(do_push ? grant : '0), .pend(irq_pend)
  );

  irq_edge_latch #(.W(1), .ACT_LOW(1'b1)) u_nmi_lat (
    .clk(clk), .rst_n(rst_n), .sig(nmi_n),
    .clr(do_push && take_nmi), .pend(nmi_pend)
  );

  irq_arb #(.N_SRC(N_SRC), .PC_W(PC_W)) u_arb (
    .pend(irq_pend), .nmi_pend(nmi_pend), .gie(gie), .mode(mode),
    .take_nmi(take_nmi), .take_irq(take_irq), .grant(grant), .vec(vec)
  );

  irq_ret_stack #(.DEPTH(STK_DEPTH), .PC_W(PC_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop),
    .din(pc_in), .top(stk_top), .ovf(stk_ovf)
  );

  irq_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .mode(mode), .we(flg_we),
    .c_wr(c_wr), .z_wr(z_wr), .c_o(c_o), .z_o(z_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode          <= MODE_NORM;
      nest_from_irq <= 1'b0;
      pc_load       <= 1'b0;
      pc_out        <= '0;
    end else if (do_pop) begin
      pc_load <= 1'b1;
      pc_out  <= stk_top;
      if (mode == MODE_NMI && nest_from_irq) mode <= MODE_IRQ;
      else                                   mode <= MODE_NORM;
    end else if (do_push) begin
      pc_load <= 1'b1;
      pc_out  <= vec;
      if (take_nmi) begin
        mode          <= MODE_NMI;
        nest_from_irq <= (mode == MODE_IRQ);
      end else begin
        mode <= MODE_IRQ;
      end
    end else begin
      pc_load <= 1'b0;
    end
  end

  assign mode_o = mode;
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int PC_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ins_end,
  input logic            reti,
  input logic            gie,
  input logic            pc_load,
  input logic [PC_W-1:0] pc_out,
  input logic [1:0]      mode_o,
  input logic            stk_ovf
);
  localparam logic [PC_W-1:0] NMI_ADDR = {PC_W{1'b1}} - PC_W'(3);

  a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_end && !reti) |=> ($stable(mode_o) && !pc_load));

  a_r10_reti_in_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && mode_o == 2'd0) |=> (!pc_load && mode_o == 2'd0));

  a_r6_reti_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && mode_o != 2'd0) |=> pc_load);

  a_r4_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && $past(mode_o) != 2'd2) |-> (pc_load && pc_out == NMI_ADDR));

  a_r2_irq_entry_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && $past(mode_o) == 2'd0) |-> ($past(gie) && $past(ins_end) && pc_load));

  a_r8_nmi_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && !reti) |=> mode_o == 2'd2);

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |=> stk_ovf);
endmodule

bind irq_seq irq_seq_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_end(ins_end), .reti(reti), .gie(gie),
  .pc_load(pc_load), .pc_out(pc_out), .mode_o(mode_o), .stk_ovf(stk_ovf)
);

// File: tb/sim_irq_seq.sv
module sim_irq_seq;
  localparam int NS = 4;
  localparam int PW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] irq_req = '0;
  logic nmi_n = 1'b1, gie = 1'b0, ins_end = 1'b0, reti = 1'b0;
  logic [PW-1:0] pc_in = '0;
  logic flg_we = 1'b0, c_wr = 1'b0, z_wr = 1'b0;
  logic pc_load, c_o, z_o, stk_ovf;
  logic [PW-1:0] pc_out;
  logic [1:0] mode_o;
  logic s_load, s_c, s_z, s_ovf;
  logic [PW-1:0] s_pc;
  logic [1:0] s_mode;

  always #5 clk = ~clk;

  irq_seq #(.N_SRC(NS), .PC_W(PW), .STK_DEPTH(6)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_n(nmi_n), .gie(gie),
    .ins_end(ins_end), .reti(reti), .pc_in(pc_in), .pc_load(pc_load),
    .pc_out(pc_out), .mode_o(mode_o), .flg_we(flg_we), .c_wr(c_wr),
    .z_wr(z_wr), .c_o(c_o), .z_o(z_o), .stk_ovf(stk_ovf));

  irq_seq #(.N_SRC(NS), .PC_W(PW), .STK_DEPTH(1)) u1 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_n(nmi_n), .gie(gie),
    .ins_end(ins_end), .reti(reti), .pc_in(pc_in), .pc_load(s_load),
    .pc_out(s_pc), .mode_o(s_mode), .flg_we(flg_we), .c_wr(c_wr),
    .z_wr(z_wr), .c_o(s_c), .z_o(s_z), .stk_ovf(s_ovf));

  int checks = 0, fails = 0;
  int m_mode = 0;
  bit m_from_irq = 0;
  bit m_nmi = 0;
  logic [NS-1:0] m_pend = '0;
  logic [PW-1:0] m_stk [8];
  int m_sp = 0;
  bit m_c [3], m_z [3];

  function automatic logic [PW-1:0] irq_vec(int i);
    return 12'hFFC - PW'(2 * (i + 1));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_flags(string req);
    chk(req, c_o, m_c[m_mode]);
    chk(req, z_o, m_z[m_mode]);
  endtask

  task automatic pulse_irq(logic [NS-1:0] bits);
    @(negedge clk); irq_req = bits;
    @(negedge clk); irq_req = '0;
    m_pend |= bits;
  endtask

  task automatic pulse_nmi();
    @(negedge clk); nmi_n = 1'b0;
    @(negedge clk); nmi_n = 1'b1;
    m_nmi = 1;
  endtask

  task automatic boundary(bit g, logic [PW-1:0] pc, string req);
    bit exp_ld;
    logic [PW-1:0] exp_pc;
    exp_ld = 0; exp_pc = '0;
    @(negedge clk); ins_end = 1'b1; gie = g; pc_in = pc;
    if (m_nmi && m_mode != 2) begin
      exp_ld = 1; exp_pc = 12'hFFC; m_nmi = 0;
      m_from_irq = (m_mode == 1); m_mode = 2;
      m_stk[m_sp] = pc; m_sp++;
    end else if (g && m_mode == 0 && m_pend != '0) begin
      for (int i = NS - 1; i >= 0; i--) if (m_pend[i]) exp_pc = irq_vec(i);
      for (int i = 0; i < NS; i++) if (m_pend[i]) begin m_pend[i] = 1'b0; break; end
      exp_ld = 1; m_mode = 1;
      m_stk[m_sp] = pc; m_sp++;
    end
    @(negedge clk); ins_end = 1'b0; gie = 1'b0;
    chk(req, pc_load, exp_ld);
    if (exp_ld) chk(req, pc_out, exp_pc);
    chk(req, mode_o, m_mode);
    chk_flags("R7");
  endtask

  task automatic do_reti(string req);
    bit exp_ld;
    logic [PW-1:0] exp_pc;
    exp_ld = 0; exp_pc = '0;
    @(negedge clk); reti = 1'b1;
    if (m_mode != 0) begin
      exp_ld = 1; m_sp--; exp_pc = m_stk[m_sp];
      m_mode = (m_mode == 2 && m_from_irq) ? 1 : 0;
    end
    @(negedge clk); reti = 1'b0;
    chk(req, pc_load, exp_ld);
    if (exp_ld) chk(req, pc_out, exp_pc);
    chk(req, mode_o, m_mode);
    chk_flags("R7");
  endtask

  task automatic wflag(bit c, bit z);
    @(negedge clk); flg_we = 1'b1; c_wr = c; z_wr = z;
    m_c[m_mode] = c; m_z[m_mode] = z;
    @(negedge clk); flg_we = 1'b0;
    chk_flags("R7");
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) begin m_c[i] = 0; m_z[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", mode_o, 0); chk("R1", pc_load, 0); chk("R1", stk_ovf, 0);
    chk("R1", c_o, 0); chk("R1", z_o, 0);
    boundary(1, 12'h100, "R1");

    // R11: pending request, gie high, no boundary -> nothing happens
    pulse_irq(4'b0100);
    @(negedge clk); gie = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R11", pc_load, 0); chk("R11", mode_o, 0);
    end
    gie = 1'b0;
    // R2: gie low blocks, then gie high takes it
    boundary(0, 12'h120, "R2");
    boundary(1, 12'h121, "R2");
    // R10: reti ignored in normal is not the case here; return first
    do_reti("R6");
    do_reti("R10");

    // R3: priority across sources and latch clear
    pulse_irq(4'b1010);
    boundary(1, 12'h200, "R3");
    do_reti("R6");
    boundary(1, 12'h201, "R3");
    do_reti("R6");
    boundary(1, 12'h202, "R3");

    // R7 + R8 + R4 + R9: nested entry through all flag pairs
    wflag(1, 0);
    boundary(1, 12'h300, "R3");
    pulse_irq(4'b0001);
    boundary(1, 12'h301, "R2");
    chk("R8", mode_o, 1);
    chk_flags("R7");
    wflag(0, 1);
    pulse_nmi();
    pulse_irq(4'b0010);
    boundary(1, 12'h302, "R4");
    chk("R9", s_ovf, 1);
    chk("R9", stk_ovf, 0);
    wflag(1, 1);
    pulse_nmi();
    boundary(1, 12'h303, "R8");
    do_reti("R6");
    boundary(1, 12'h304, "R4");
    do_reti("R6");
    do_reti("R6");
    boundary(1, 12'h305, "R8");
    do_reti("R6");
    boundary(1, 12'h306, "R8");
    do_reti("R6");

    // R4: NMI beats maskable and ignores gie
    pulse_irq(4'b0001);
    pulse_nmi();
    boundary(0, 12'h400, "R4");
    do_reti("R6");
    boundary(1, 12'h401, "R3");
    do_reti("R6");

    // R5: held-low NMI gives one entry
    @(negedge clk); nmi_n = 1'b0; m_nmi = 1;
    boundary(0, 12'h500, "R5");
    do_reti("R6");
    boundary(0, 12'h501, "R5");
    boundary(0, 12'h502, "R5");
    @(negedge clk); nmi_n = 1'b1;

    // R10: reti with concurrent ins_end in normal mode
    pulse_irq(4'b1000);
    @(negedge clk); reti = 1'b1; ins_end = 1'b1; gie = 1'b1;
    @(negedge clk); reti = 1'b0; ins_end = 1'b0; gie = 1'b0;
    chk("R10", pc_load, 0); chk("R10", mode_o, 0);
    boundary(1, 12'h600, "R3");
    do_reti("R6");

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 7;
      case (op)
        0: pulse_irq(NS'($urandom % 15 + 1));
        1: pulse_nmi();
        2, 3: boundary(1'($urandom % 2), PW'($urandom), "R2");
        4, 5: do_reti("R6");
        default: wflag(1'($urandom % 2), 1'($urandom % 2));
      endcase
    end
    chk("R9", stk_ovf, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule